// File: doc/BRIEF.md
# Immediate Add Unit with Range-Error Trap

This execution unit adds an immediate constant to a source operand for a 32-bit processor pipeline. It produces the destination value together with zero, negative, overflow and carry flags. Each request carries a variant select. The plain variant treats the operands as either signed or unsigned and never traps. The trapping variant treats them as signed and raises a range-error strobe when the signed result overflows.

A second select swaps the register operand for the current carry flag, zero-extended to the data width. In that mode the flags are still computed for the chosen variant, but the range-error strobe is held off even when the trapping variant is selected.

All outputs are registered. The result and flags appear one clock after an accepted request, and they stay on the outputs until the next request or a reset. A handler can therefore read the result and flags that caused a trap. An unsigned subtract is made by adding the negated immediate. In that case a clear carry flag means a borrow below zero.

Top module: `iadd_unit`

## Requirements
- R1: One clock after a request with `req_valid` high, `res_data` equals the low 32 bits of the selected operand plus `req_imm`. For example, 0x00000004 plus 0x120 gives 0x00000124 with all four flags clear.
- R2: `flag_z` is 1 exactly when the registered result is zero.
- R3: `flag_n` equals bit 31 of the registered result.
- R4: `flag_v` is 1 exactly when both operands have the same bit 31 and the sum's bit 31 differs from it (two's-complement overflow).
- R5: `flag_c` is the carry out of bit 31 of the unsigned addition. When the immediate is the negated subtrahend, `flag_c` = 0 signals a borrow below zero.
- R6: When `req_use_carry` is 1, the operand is `req_carry_in` zero-extended to 32 bits and `req_src` is ignored. The flags follow R2 to R5.
- R7: When `req_trap_en` is 1 (trapping signed variant), `req_use_carry` is 0 and the sum overflows, `trap_range` is 1 for exactly the one cycle in which the result is presented.
- R8: `trap_range` stays 0 for every request with `req_trap_en` = 0, and for every request with `req_use_carry` = 1.
- R9: `res_valid` is a one-cycle strobe one clock after each request. In cycles with no request, `res_valid` and `trap_range` are 0, and `res_data` and the flags keep their last values.
- R10: While `rst` (synchronous, active high) is sampled high, all outputs and strobes are cleared to 0 at the next clock edge.
- R11: When `trap_range` is 1, `res_data` and the four flags show the overflowed sum as defined in R1 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request qualifier |
| req_src | input | 32 | Register source operand |
| req_imm | input | 32 | Immediate constant |
| req_trap_en | input | 1 | 1 = signed variant with range-error trap, 0 = plain sum |
| req_use_carry | input | 1 | 1 = use carry flag as the operand instead of req_src |
| req_carry_in | input | 1 | Current carry flag value |
| res_valid | output | 1 | Result strobe, one cycle |
| res_data | output | 32 | Registered sum |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Unsigned carry flag |
| trap_range | output | 1 | Range-error trap strobe, one cycle |

## Verification
Every result, flag and strobe is due exactly one clock after the request that caused it. The bench drives each request on a falling edge, removes it on the next falling edge, and samples all outputs then, after the single rising edge in between. Idle cycles are sampled the same way, to confirm that the strobes drop and the data holds. Reset is checked at the falling edge after the reset edge.

// File: rtl/iadd_pkg.sv
package iadd_pkg;
  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic c;
  } iadd_flags_t;
endpackage

// File: rtl/iadd_opsel.sv
module iadd_opsel #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] src,
  input  logic              use_carry,
  input  logic              carry_in,
  output logic [DATA_W-1:0] opnd
);
  function automatic logic [DATA_W-1:0] widen_bit(input logic b);
    logic [DATA_W-1:0] w;
    w = '0;
    w[0] = b;
    return w;
  endfunction

  always_comb begin
    if (use_carry) opnd = widen_bit(carry_in);
    else           opnd = src;
  end
endmodule

// File: rtl/iadd_adder.sv
module iadd_adder
  import iadd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum,
  output iadd_flags_t       flags
);
  localparam int unsigned MSB = DATA_W - 1;

  function automatic logic [DATA_W:0] add_wide(input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic sgn_ovf(input logic xs, input logic ys, input logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

  logic [DATA_W:0] wide;

  always_comb begin
    wide    = add_wide(a, b);
    sum     = wide[DATA_W-1:0];
    flags.z = (wide[DATA_W-1:0] == '0);
    flags.n = wide[MSB];
    flags.v = sgn_ovf(a[MSB], b[MSB], wide[MSB]);
    flags.c = wide[DATA_W];
  end
endmodule

// File: rtl/iadd_trap.sv
module iadd_trap (
  input  logic trap_en,
  input  logic use_carry,
  input  logic ovf,
  output logic fire
);
  always_comb fire = trap_en && !use_carry && ovf;
endmodule

// File: rtl/iadd_unit.sv
module iadd_unit
  import iadd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [DATA_W-1:0] req_src,
  input  logic [DATA_W-1:0] req_imm,
  input  logic              req_trap_en,
  input  logic              req_use_carry,
  input  logic              req_carry_in,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data,
  output logic              flag_z,
  output logic              flag_n,
  output logic              flag_v,
  output logic              flag_c,
  output logic              trap_range
);
  logic [DATA_W-1:0] sel_opnd;
  logic [DATA_W-1:0] raw_sum;
  iadd_flags_t       raw_flags;
  logic              trap_fire;

  iadd_opsel #(.DATA_W(DATA_W)) u_opsel (
    .src(req_src), .use_carry(req_use_carry), .carry_in(req_carry_in), .opnd(sel_opnd)
  );

  iadd_adder #(.DATA_W(DATA_W)) u_adder (
    .a(sel_opnd), .b(req_imm), .sum(raw_sum), .flags(raw_flags)
  );

  iadd_trap u_trap (
    .trap_en(req_trap_en), .use_carry(req_use_carry), .ovf(raw_flags.v), .fire(trap_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_data   <= '0;
      flag_z     <= 1'b0;
      flag_n     <= 1'b0;
      flag_v     <= 1'b0;
      flag_c     <= 1'b0;
      trap_range <= 1'b0;
    end else begin
      res_valid  <= req_valid;
      trap_range <= req_valid && trap_fire;
      if (req_valid) begin
        res_data <= raw_sum;
        flag_z   <= raw_flags.z;
        flag_n   <= raw_flags.n;
        flag_v   <= raw_flags.v;
        flag_c   <= raw_flags.c;
      end
    end
  end
endmodule

// File: rtl/iadd_unit_chk.sv
module iadd_unit_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [DATA_W-1:0] req_src,
  input logic [DATA_W-1:0] req_imm,
  input logic              req_trap_en,
  input logic              req_use_carry,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data,
  input logic              flag_z,
  input logic              flag_n,
  input logic              flag_v,
  input logic              trap_range,
  input logic              ovf_raw,
  input logic              trap_fire
);
  localparam int unsigned MSB = DATA_W - 1;
  logic rst_seen = 1'b0;

  always_ff @(posedge clk) rst_seen <= rst;

  always @(negedge clk) begin
    if (rst_seen) begin
      assert_reset_clear_R10: assert (!res_valid && !trap_range && res_data == '0 && !flag_z && !flag_n && !flag_v);
    end
  end

  assert_sum_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_use_carry |=> res_data == ($past(req_src) + $past(req_imm)));

  assert_zero_R2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> flag_z == (res_data == '0));

  assert_sign_R3: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> flag_n == res_data[MSB]);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_use_carry && (req_src[MSB] != req_imm[MSB]) |=> !flag_v);

  assert_trap_raised_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_trap_en && !req_use_carry && ovf_raw |=> trap_range);

  assert_no_trap_carry_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid && (req_use_carry || !req_trap_en) |=> !trap_range);

  assert_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid && !trap_range && $stable(res_data));

  assert_trap_with_result_R11: assert property (@(posedge clk) disable iff (rst)
    trap_range |-> res_valid && flag_v);

  assert_fire_source_R7: assert property (@(posedge clk) disable iff (rst)
    trap_fire |-> ovf_raw && req_trap_en);
endmodule

bind iadd_unit iadd_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src), .req_imm(req_imm),
  .req_trap_en(req_trap_en), .req_use_carry(req_use_carry), .res_valid(res_valid),
  .res_data(res_data), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
  .trap_range(trap_range), .ovf_raw(raw_flags.v), .trap_fire(trap_fire)
);

// File: tb/iadd_unit_tb.sv
module iadd_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_src = '0;
  logic [31:0] req_imm = '0;
  logic        req_trap_en = 1'b0;
  logic        req_use_carry = 1'b0;
  logic        req_carry_in = 1'b0;
  logic        res_valid, flag_z, flag_n, flag_v, flag_c, trap_range;
  logic [31:0] res_data;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  iadd_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src), .req_imm(req_imm),
    .req_trap_en(req_trap_en), .req_use_carry(req_use_carry), .req_carry_in(req_carry_in),
    .res_valid(res_valid), .res_data(res_data), .flag_z(flag_z), .flag_n(flag_n),
    .flag_v(flag_v), .flag_c(flag_c), .trap_range(trap_range)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference computed through 64-bit integer arithmetic.
  task automatic run_op(input logic [31:0] s, input logic [31:0] i, input bit trap_en,
                        input bit use_c, input bit cin);
    longint unsigned us;
    longint          ss;
    logic [31:0]     a, r;
    bit              ev, ec;
    a  = use_c ? {31'b0, cin} : s;
    us = longint'(a) + longint'(i);
    ss = longint'($signed(a)) + longint'($signed(i));
    r  = us[31:0];
    ec = us[32];
    ev = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
    @(negedge clk);
    req_valid = 1'b1; req_src = s; req_imm = i;
    req_trap_en = trap_en; req_use_carry = use_c; req_carry_in = cin;
    @(negedge clk);
    req_valid = 1'b0;
    req_src = $urandom; req_imm = $urandom;
    check("R1 data", {32'b0, res_data}, {32'b0, r});
    check("R9 valid", {63'b0, res_valid}, 64'd1);
    check("R2 zero", {63'b0, flag_z}, {63'b0, (r == 32'd0)});
    check("R3 neg", {63'b0, flag_n}, {63'b0, r[31]});
    check("R4 ovf", {63'b0, flag_v}, {63'b0, ev});
    check("R5 carry", {63'b0, flag_c}, {63'b0, ec});
    check("R7/R8 trap", {63'b0, trap_range}, {63'b0, (trap_en && !use_c && ev)});
  endtask

  task automatic check_idle();
    logic [31:0] held;
    logic [3:0]  hf;
    held = res_data;
    hf = {flag_z, flag_n, flag_v, flag_c};
    @(negedge clk);
    check("R9 idle valid", {63'b0, res_valid}, 64'd0);
    check("R9 idle trap", {63'b0, trap_range}, 64'd0);
    check("R9 idle data", {32'b0, res_data}, {32'b0, held});
    check("R9 idle flags", {60'b0, flag_z, flag_n, flag_v, flag_c}, {60'b0, hf});
  endtask

  task automatic check_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 reset", {27'b0, res_valid, trap_range, flag_z, flag_n, flag_v, flag_c, res_data},
          64'd0);
  endtask

  initial begin
    void'($urandom(32'd7411));
    check_reset();
    run_op(32'h4, 32'h120, 0, 0, 0);                       // R1 example
    run_op(32'hFFFF_FFFC, 32'h4, 0, 0, 0);                 // R2 zero, R5 carry
    run_op(32'h7FFF_FFFF, 32'h1, 1, 0, 0);                 // R7 trap, R11
    check("R11 data on trap", {32'b0, res_data}, 64'h8000_0000);
    run_op(32'h7FFF_FFFF, 32'h1, 0, 0, 0);                 // R8 plain no trap
    run_op(32'h8000_0000, 32'h8000_0000, 1, 0, 0);         // R4 neg overflow
    run_op(32'h3, 32'hFFFF_FFFB, 0, 0, 0);                 // R5 borrow
    run_op(32'h5, 32'hFFFF_FFFD, 0, 0, 0);                 // R5 no borrow
    run_op(32'hDEAD_BEEF, 32'h7FFF_FFFF, 1, 1, 1);         // R6 carry src, R8 no trap
    run_op(32'h1234_5678, 32'hFFFF_FFFF, 1, 1, 1);         // R6 wrap to zero
    run_op(32'hFFFF_FFFF, 32'h10, 1, 1, 0);                // R6 cin 0
    check_idle();                                           // R9
    check_idle();
    for (int k = 0; k < 300; k++) begin
      logic [31:0] s, i;
      s = $urandom; i = $urandom;
      if (k % 5 == 0) i = {~s[31], i[30:0]};
      if (k % 7 == 0) begin s[31] = 1'b0; i[31] = 1'b0; s[30] = 1'b1; i[30] = 1'b1; end
      run_op(s, i, bit'($urandom % 2), bit'(($urandom % 4) == 0), bit'($urandom % 2));
      if (k % 11 == 0) check_idle();
    end
    check_reset();
    run_op(32'h4, 32'h120, 1, 0, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule